// File: doc/BRIEF.md
# Four-Axis Encoder Host Register Port

This block sits between a byte-wide host port and the position logic of a four-axis quadrature encoder card. The host first sends an address byte with an address strobe. The high nibble of that byte picks the card, and the low nibble sets an internal byte pointer. Each later data strobe reads or writes one byte at the pointer, and the pointer then steps on by one. A host can therefore fetch every counter with one address cycle followed by a burst of data reads.

On reads the block returns bytes of the four 24-bit counters. When the low byte of any axis is read, all four counters are captured together, so the middle and high bytes that follow come from that same instant and a count arriving between bytes cannot tear the value. Reads also return a sticky index-sense byte, which clears when read, and a fixed identification code. The same addresses mean something else on writes. There, the block assembles a 24-bit preset from three bytes and holds a control byte carrying per-axis load commands, a timer configuration byte, a filter-rate byte and per-axis index-preset enables. All of these drive the counter logic next to it.

Top module: `quad_reg_port`

## Requirements
- R1: An address strobe selects the card only when its bits 7:4 equal the bitwise inverse of `sel_n` (a switch input of 0 means a 1 bit). While the card is not selected, data strobes change neither `dout` nor any write-side output.
- R2: An address strobe loads the pointer from bits 3:0. Each data strobe to the selected card advances the pointer by one, and it wraps from 15 to 0. If an address strobe and a data strobe arrive together, the address strobe wins and the data strobe is dropped.
- R3: Reads at addresses 0 to 11 return counter bytes at address 3*axis+k, where k=0 is bits 7:0, k=1 is bits 15:8 and k=2 is bits 23:16, for axes 0 to 3.
- R4: A read of any axis low byte returns that counter's live bits 7:0 and, at the same edge, captures all four counters. Middle and high byte reads return the most recent capture.
- R5: Read address 12 returns the index flags in bits 3:0 (bit n for axis n) with bits 7:4 zero. A pulse on `idx_evt` sets a flag, and the flag holds until that read clears it. An event in the same cycle as the clearing read is kept.
- R6: Read address 15 returns 0x14. Read addresses 13 and 14 return 0x00.
- R7: Writes to addresses 0, 1 and 2 load `asm_val` bits 7:0, 15:8 and 23:16.
- R8: A write to address 3 sets `load_cmd[n]` from data bit 4+n. `load_cmd` holds until address 3 is written again.
- R9: A write to address 4 loads `timer_cfg`. A write to address 5 loads `filt_rate`.
- R10: A write to address 13 loads `idx_preset` from data bits 3:0, and bits 7:4 are dropped.
- R11: Writes to addresses 6 to 12, 14 and 15 change no output.
- R12: After reset every output is zero and the card is deselected.
- R13: `dout` changes only on the clock edge that follows a read strobe to the selected card. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adr_stb | input | 1 | Address strobe, one cycle |
| dat_stb | input | 1 | Data strobe, one cycle |
| wr | input | 1 | 1 = data strobe is a write |
| din | input | 8 | Host address or write data |
| sel_n | input | 4 | Card select switches, active-low |
| cnt_in | input | 96 | Live counters, axis n at bits 24n+23:24n |
| idx_evt | input | 4 | Index detection pulses per axis |
| dout | output | 8 | Registered read data |
| asm_val | output | 24 | Assembled preset value |
| load_cmd | output | 4 | Per-axis load-position commands |
| timer_cfg | output | 8 | Timer configuration byte |
| filt_rate | output | 8 | Filter rate select byte |
| idx_preset | output | 4 | Per-axis index-preset enables |

## Verification
A pointer that slips shows up on the very next read as a byte taken from the wrong counter or from the wrong part of a counter. A burst of twelve reads therefore exposes a slip within one strobe. A capture that fires at the wrong moment appears as middle or high bytes that follow the live counter instead of the value seen at the low-byte read. The bench moves the counters after every strobe so that this difference always shows. A missed clear of the index flags, or a write landing at the wrong address, becomes visible at the next read of address 12 or on the write-side outputs one cycle after the strobe.

// File: rtl/qrp_pkg.sv
package qrp_pkg;
   localparam int unsigned PTR_W   = 4;
   localparam int unsigned BYTE_W  = 8;
   localparam logic [3:0]  A_CTRL  = 4'd3;
   localparam logic [3:0]  A_TIMER = 4'd4;
   localparam logic [3:0]  A_FILT  = 4'd5;
   localparam logic [3:0]  A_INDEX = 4'd12;
   localparam logic [3:0]  A_PRE   = 4'd13;
   localparam logic [3:0]  A_IDENT = 4'd15;
endpackage

// File: rtl/qrp_addr.sv
module qrp_addr #(
   parameter int unsigned PW = 4,
   parameter int unsigned SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adr_stb,
   input  logic          dat_stb,
   input  logic [7:0]    din,
   input  logic [SW-1:0] sel_n,
   output logic          sel,
   output logic [PW-1:0] ptr,
   output logic          xfer
);
   if (PW + SW != 8) begin : g_bad_split
      $error("pointer and select widths must fill one byte");
   end

   assign xfer = dat_stb & sel & ~adr_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= 1'b0;
         ptr <= '0;
      end else if (adr_stb) begin
         sel <= (din[7 -: SW] == ~sel_n);
         ptr <= din[PW-1:0];
      end else if (xfer) begin
         ptr <= ptr + 1'b1;
      end
   end
endmodule

// File: rtl/qrp_snap.sv
module qrp_snap #(
   parameter int unsigned AXES = 4,
   parameter int unsigned CW   = 24,
   parameter int unsigned PW   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic [PW-1:0]     ptr,
   input  logic [AXES*CW-1:0] cnt_in,
   output logic [7:0]        rbyte
);
   localparam int unsigned BPA = CW / 8;
   localparam int unsigned HW  = CW - 8;

   if (CW % 8 != 0 || CW < 16) begin : g_bad_cw
      $error("counter width must be a whole number of bytes, at least two");
   end

   logic [AXES-1:0] lo_hit;
   logic [HW-1:0]   hold [AXES];

   for (genvar a = 0; a < AXES; a++) begin : g_axis
      assign lo_hit[a] = (ptr == PW'(a * BPA));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hold[a] <= '0;
         else if (rd && |lo_hit)
            hold[a] <= cnt_in[a*CW+8 +: HW];
      end
   end

   always_comb begin
      rbyte = '0;
      for (int a = 0; a < AXES; a++) begin
         if (lo_hit[a])
            rbyte = cnt_in[a*CW +: 8];
         for (int b = 1; b < BPA; b++) begin
            if (ptr == PW'(a * BPA + b))
               rbyte = hold[a][(b-1)*8 +: 8];
         end
      end
   end
endmodule

// File: rtl/qrp_idx.sv
module qrp_idx #(
   parameter int unsigned AXES = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic [AXES-1:0] evt,
   output logic [AXES-1:0] flags
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags <= '0;
      else
         flags <= (clr ? '0 : flags) | evt;
   end
endmodule

// File: rtl/qrp_wregs.sv
module qrp_wregs
   import qrp_pkg::*;
#(
   parameter int unsigned AXES = 4,
   parameter int unsigned CW   = 24,
   parameter int unsigned PW   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [PW-1:0]   ptr,
   input  logic [7:0]      din,
   output logic [CW-1:0]   asm_val,
   output logic [AXES-1:0] load_cmd,
   output logic [7:0]      timer_cfg,
   output logic [7:0]      filt_rate,
   output logic [AXES-1:0] idx_preset
);
   localparam int unsigned BPA = CW / 8;

   if (AXES > 4) begin : g_bad_axes
      $error("control nibble holds at most four axes");
   end

   for (genvar b = 0; b < BPA; b++) begin : g_asm
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            asm_val[b*8 +: 8] <= '0;
         else if (we && ptr == PW'(b))
            asm_val[b*8 +: 8] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_cmd   <= '0;
         timer_cfg  <= '0;
         filt_rate  <= '0;
         idx_preset <= '0;
      end else if (we) begin
         unique case (ptr)
            PW'(A_CTRL):  load_cmd   <= din[4 +: AXES];
            PW'(A_TIMER): timer_cfg  <= din;
            PW'(A_FILT):  filt_rate  <= din;
            PW'(A_PRE):   idx_preset <= din[AXES-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/quad_reg_port.sv
module quad_reg_port
   import qrp_pkg::*;
#(
   parameter int unsigned AXES  = 4,
   parameter int unsigned CW    = 24,
   parameter logic [7:0]  IDENT = 8'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adr_stb,
   input  logic              dat_stb,
   input  logic              wr,
   input  logic [7:0]        din,
   input  logic [3:0]        sel_n,
   input  logic [AXES*CW-1:0] cnt_in,
   input  logic [AXES-1:0]   idx_evt,
   output logic [7:0]        dout,
   output logic [CW-1:0]     asm_val,
   output logic [AXES-1:0]   load_cmd,
   output logic [7:0]        timer_cfg,
   output logic [7:0]        filt_rate,
   output logic [AXES-1:0]   idx_preset
);
   localparam int unsigned AX_BYTES = AXES * (CW / 8);

   if (AX_BYTES > int'(A_INDEX)) begin : g_bad_map
      $error("counter bytes overlap the index address");
   end

   logic          brd_sel;
   logic [PTR_W-1:0] ptr;
   logic          xfer;
   logic          rd;
   logic [7:0]    ax_byte;
   logic [AXES-1:0] idx_flags;
   logic [7:0]    rdata;

   assign rd = xfer & ~wr;

   qrp_addr #(.PW(PTR_W), .SW(4)) u_addr (
      .clk(clk), .rst_n(rst_n), .adr_stb(adr_stb), .dat_stb(dat_stb),
      .din(din), .sel_n(sel_n), .sel(brd_sel), .ptr(ptr), .xfer(xfer)
   );

   qrp_snap #(.AXES(AXES), .CW(CW), .PW(PTR_W)) u_snap (
      .clk(clk), .rst_n(rst_n), .rd(rd), .ptr(ptr),
      .cnt_in(cnt_in), .rbyte(ax_byte)
   );

   qrp_idx #(.AXES(AXES)) u_idx (
      .clk(clk), .rst_n(rst_n), .clr(rd && ptr == A_INDEX),
      .evt(idx_evt), .flags(idx_flags)
   );

   qrp_wregs #(.AXES(AXES), .CW(CW), .PW(PTR_W)) u_wregs (
      .clk(clk), .rst_n(rst_n), .we(xfer & wr), .ptr(ptr), .din(din),
      .asm_val(asm_val), .load_cmd(load_cmd), .timer_cfg(timer_cfg),
      .filt_rate(filt_rate), .idx_preset(idx_preset)
   );

   always_comb begin
      rdata = '0;
      if (ptr < PTR_W'(AX_BYTES))
         rdata = ax_byte;
      else if (ptr == A_INDEX)
         rdata[AXES-1:0] = idx_flags;
      else if (ptr == A_IDENT)
         rdata = IDENT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout <= '0;
      else if (rd)
         dout <= rdata;
   end
endmodule

module quad_reg_port_chk #(
   parameter int unsigned AXES  = 4,
   parameter int unsigned CW    = 24,
   parameter logic [7:0]  IDENT = 8'h14
) (
   input logic            clk,
   input logic            rst_n,
   input logic            adr_stb,
   input logic            dat_stb,
   input logic            wr,
   input logic            sel,
   input logic [3:0]      ptr,
   input logic [AXES-1:0] idx_evt,
   input logic [AXES-1:0] idx_flags,
   input logic [7:0]      dout,
   input logic [CW-1:0]   asm_val,
   input logic [AXES-1:0] load_cmd
);
   logic acc;
   assign acc = sel & dat_stb & ~adr_stb;

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> ptr == $past(ptr) + 4'd1); // R2
   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && !wr) |=> $stable(dout)); // R13
   AST_IDENT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !wr && ptr == 4'd15) |=> dout == IDENT); // R6
   AST_INDEX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !wr && ptr == 4'd12 && idx_evt == '0) |=> idx_flags == '0); // R5
   AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> $stable(asm_val)); // R1
   AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && wr && ptr == 4'd3) |=> $stable(load_cmd)); // R8
endmodule

bind quad_reg_port quad_reg_port_chk #(.AXES(AXES), .CW(CW), .IDENT(IDENT)) u_chk (
   .clk(clk), .rst_n(rst_n), .adr_stb(adr_stb), .dat_stb(dat_stb), .wr(wr),
   .sel(brd_sel), .ptr(ptr), .idx_evt(idx_evt), .idx_flags(idx_flags),
   .dout(dout), .asm_val(asm_val), .load_cmd(load_cmd)
);

// File: tb/quad_reg_port_tb.sv
module quad_reg_port_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adr_stb = 1'b0, dat_stb = 1'b0, wr = 1'b0;
   logic [7:0]  din = '0;
   logic [3:0]  sel_n = 4'b1101;
   logic [23:0] cnt [4];
   logic [95:0] cnt_in;
   logic [3:0]  idx_evt = '0;
   logic [7:0]  dout;
   logic [23:0] asm_val;
   logic [3:0]  load_cmd, idx_preset;
   logic [7:0]  timer_cfg, filt_rate;

   int n_run = 0, n_fail = 0;
   logic rd_req = 1'b0;
   bit   done = 1'b0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   logic        m_sel = 1'b0;
   logic [3:0]  m_ptr = '0;
   logic [23:0] m_snap [4];
   logic [3:0]  m_flags = '0;
   logic [7:0]  m_last = '0;

   assign cnt_in = {cnt[3], cnt[2], cnt[1], cnt[0]};

   always #(CLK_P/2) clk = ~clk;

   quad_reg_port u_dut (
      .clk(clk), .rst_n(rst_n), .adr_stb(adr_stb), .dat_stb(dat_stb), .wr(wr),
      .din(din), .sel_n(sel_n), .cnt_in(cnt_in), .idx_evt(idx_evt),
      .dout(dout), .asm_val(asm_val), .load_cmd(load_cmd),
      .timer_cfg(timer_cfg), .filt_rate(filt_rate), .idx_preset(idx_preset)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   // scoreboard monitor: one compare per read strobe
   initial forever begin
      @(posedge clk);
      if (rd_req) begin
         #(CLK_P/4);
         chk(tag_q.pop_front(), {24'h0, dout}, {24'h0, exp_q.pop_front()});
      end
   end

   task automatic set_addr(input logic [7:0] a);
      @(negedge clk); din = a; adr_stb = 1'b1;
      @(negedge clk); adr_stb = 1'b0;
      m_sel = (a[7:4] == ~sel_n);
      m_ptr = a[3:0];
   endtask

   task automatic rd(input string tag);
      logic [7:0] e;
      e = m_last;
      if (m_sel) begin
         if (m_ptr < 4'd12) begin
            if (m_ptr % 3 == 0) begin
               for (int k = 0; k < 4; k++) m_snap[k] = cnt[k];
               e = cnt[m_ptr/3][7:0];
            end else begin
               e = m_snap[m_ptr/3][8*(m_ptr%3) +: 8];
            end
         end else if (m_ptr == 4'd12) begin
            e = {4'h0, m_flags};
            m_flags = '0;
         end else if (m_ptr == 4'd15) e = 8'h14;
         else e = 8'h00;
         m_ptr = m_ptr + 4'd1;
      end
      m_last = e;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk); dat_stb = 1'b1; wr = 1'b0; rd_req = 1'b1;
      @(negedge clk); dat_stb = 1'b0; rd_req = 1'b0;
   endtask

   task automatic wbyte(input logic [7:0] d);
      @(negedge clk); din = d; dat_stb = 1'b1; wr = 1'b1;
      @(negedge clk); dat_stb = 1'b0; wr = 1'b0;
      if (m_sel) m_ptr = m_ptr + 4'd1;
   endtask

   task automatic bump();
      for (int k = 0; k < 4; k++) cnt[k] = cnt[k] + 24'h010203 * (k + 1);
   endtask

   initial begin
      #(CLK_P * 5000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      cnt[0] = 24'h123456; cnt[1] = 24'hFEDCBA; cnt[2] = 24'h800001; cnt[3] = 24'h00FF7F;
      for (int k = 0; k < 4; k++) m_snap[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 dout", {24'h0, dout}, 0);
      chk("R12 asm_val", {8'h0, asm_val}, 0);
      chk("R12 load/preset", {24'h0, load_cmd, idx_preset}, 0);
      chk("R12 timer/filt", {16'h0, timer_cfg, filt_rate}, 0);
      // R12 deselected after reset: write and read do nothing
      wbyte(8'h55);
      chk("R12 unselected write", {8'h0, asm_val}, 0);
      rd("R12 unselected read");

      // R3 R4 burst of twelve with counters moving after every strobe
      set_addr(8'h20);
      for (int i = 0; i < 12; i++) begin
         rd($sformatf("R3/R4 burst byte %0d", i));
         bump();
      end

      // R2 R6 pointer wrap, unused reads, ident
      set_addr(8'h2D);
      rd("R6 addr13"); rd("R6 addr14"); rd("R6 ident"); rd("R2 wrap to 0");
      rd("R4 mid after wrap");

      // R5 index flags, clear on read
      @(negedge clk); idx_evt = 4'b0101;
      @(negedge clk); idx_evt = 4'b0000; m_flags = m_flags | 4'b0101;
      set_addr(8'h2C); rd("R5 flags set");
      set_addr(8'h2C); rd("R5 flags cleared");

      // R1 other card address
      set_addr(8'h30);
      rd("R1 other card read");
      wbyte(8'h77);
      chk("R1 other card write", {8'h0, asm_val}, 0);

      // R7 R8 R9 writes
      set_addr(8'h20);
      wbyte(8'h11); wbyte(8'h22); wbyte(8'h33);
      wbyte(8'hA5); wbyte(8'h3C); wbyte(8'h0F);
      chk("R7 asm_val", {8'h0, asm_val}, 32'h332211);
      chk("R8 load_cmd", {28'h0, load_cmd}, 32'hA);
      chk("R9 timer_cfg", {24'h0, timer_cfg}, 32'h3C);
      chk("R9 filt_rate", {24'h0, filt_rate}, 32'h0F);
      chk("R13 dout after writes", {24'h0, dout}, {24'h0, m_last});

      // R10 R11 preset and ignored addresses, wrap into asm low
      set_addr(8'h2C);
      wbyte(8'hFF); wbyte(8'h9B); wbyte(8'hEE); wbyte(8'hDD); wbyte(8'h44);
      chk("R10 idx_preset", {28'h0, idx_preset}, 32'hB);
      chk("R11 load_cmd kept", {28'h0, load_cmd}, 32'hA);
      chk("R11 timer/filt kept", {16'h0, timer_cfg, filt_rate}, 32'h3C0F);
      chk("R2 write wrap asm", {8'h0, asm_val}, 32'h332244);
      set_addr(8'h2C); rd("R11 index untouched by write");

      // R8 clear load command; R3 read of address 0 is counter not asm
      set_addr(8'h23); wbyte(8'h00);
      chk("R8 load cleared", {28'h0, load_cmd}, 0);
      set_addr(8'h20); rd("R3 read addr0 is counter");
      bump(); rd("R4 mid from capture");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule